// File: doc/BRIEF.md
# Down-Counting Timer and Pseudo-Random CSR Block

This block provides three machine-level control registers for a processor core. The first is a time register that counts down by one on every clock. The second is a compare register that software can read and write. The third is a 32-bit linear feedback shift register (LFSR) that supplies pseudo-random values. A timer-pending flag is raised when the time register reaches the compare value, and it stays raised until software writes the compare register again.

The core's CSR stage drives an address, write data and a write strobe. Read data comes back one clock later from a register. A privilege input says whether the access is made in machine mode. Accesses made outside machine mode read as zero and have no effect. A separate hardware port loads a new seed into the LFSR. A zero seed is swapped for a fixed nonzero constant, so the generator can never stall.

Top module: `csr_timer_rng`

## Requirements
- R1: Reset is synchronous and active high. After reset the time register holds 32'hFFFFFFFF, the compare register holds 0, the LFSR holds 32'h1D872B41, and both `csr_rd_data` and `timer_irq` are 0.
- R2: Outside reset, the time register decreases by exactly one on every clock and wraps from 0 to all ones.
- R3: Reads are registered. When an address is presented before a clock edge, `csr_rd_data` after that edge holds the value the addressed register had before the edge. The addresses are: time 12'h7C0, compare 12'h7C1, random 12'h7C2. Any other address reads as 0.
- R4: A machine-mode write to 12'h7C1 loads `csr_wr_data` into the compare register. The compare register changes on no other event.
- R5: Writes to the time address (12'h7C0) and the random address (12'h7C2) are ignored. Both registers keep their hardware sequence.
- R6: `timer_irq` rises at the clock edge that ends a cycle in which time equals compare. It then stays high.
- R7: A machine-mode write to the compare register clears `timer_irq` at that edge. The clear takes priority over a match in the same cycle.
- R8: On every clock without a seed load, the LFSR steps as next = {q[30:0], q[31]^q[21]^q[1]^q[0]}. This is the polynomial x^32+x^22+x^2+x+1.
- R9: When `seed_load` is high, the LFSR takes `seed_value` at that edge instead of stepping.
- R10: A seed of zero loads the constant 32'h1D872B41 instead. The LFSR never holds zero.
- R11: When `priv_machine` is 0, the read returns 0 and any write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_machine | input | 1 | High when the access is made in machine mode |
| csr_addr | input | 12 | CSR address |
| csr_wr_en | input | 1 | Write strobe |
| csr_wr_data | input | 32 | Write data |
| csr_rd_data | output | 32 | Registered read data |
| seed_load | input | 1 | Hardware seed load strobe |
| seed_value | input | 32 | Seed for the LFSR |
| timer_irq | output | 1 | Sticky timer-pending flag |

## Verification
The time register is read on back-to-back cycles and with a gap of a known length. The differences must match the elapsed cycles, which separates a correct decrement from a stalled counter, a wrong step size or an extra read stage. The compare register is set a fixed number of cycles ahead of the time value just read. The flag is then checked on the exact edge where it must rise, checked again ten cycles later, and checked after the compare write that must clear it. This separates an off-by-one match, a flag that is not sticky, and a missing clear. The LFSR is checked against an independent model in four situations: after a nonzero seed, after a zero seed, after a write to its address, and after reset. Together these show the tap positions, the seed priority and the substitution for a zero seed. Writes and reads made outside machine mode, and reads of unmapped addresses, must leave no trace.

// File: rtl/csrt_pkg.sv
package csrt_pkg;
  localparam int unsigned CSRT_ADDR_W = 12;
  localparam int unsigned CSRT_DATA_W = 32;
  localparam logic [CSRT_ADDR_W-1:0] CSRT_A_TIME = 12'h7C0;
  localparam logic [CSRT_ADDR_W-1:0] CSRT_A_CMP  = 12'h7C1;
  localparam logic [CSRT_ADDR_W-1:0] CSRT_A_RAND = 12'h7C2;
  localparam logic [CSRT_DATA_W-1:0] CSRT_RAND_DEF  = 32'h1D87_2B41;
  localparam logic [CSRT_DATA_W-1:0] CSRT_RAND_TAPS = 32'h8020_0003;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_TIME = 2'd1,
    SEL_CMP  = 2'd2,
    SEL_RAND = 2'd3
  } csrt_sel_e;
endpackage

// File: rtl/csrt_down_timer.sv
module csrt_down_timer #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmp_we,
  input  logic [W-1:0] cmp_wdata,
  output logic [W-1:0] time_o,
  output logic [W-1:0] cmp_o,
  output logic         irq_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] time_q;
  logic [W-1:0] cmp_q;
  logic         irq_q;
  logic         hit;

  assign hit = (time_q == cmp_q);

  // Free-running down counter, wraps naturally from zero to all ones
  always_ff @(posedge clk) begin
    if (rst) time_q <= '1;
    else     time_q <= time_q - ONE;
  end

  always_ff @(posedge clk) begin
    if (rst)         cmp_q <= '0;
    else if (cmp_we) cmp_q <= cmp_wdata;
  end

  // Sticky pending flag; a compare write wins over a same-cycle hit
  always_ff @(posedge clk) begin
    if (rst)         irq_q <= 1'b0;
    else if (cmp_we) irq_q <= 1'b0;
    else if (hit)    irq_q <= 1'b1;
  end

  assign time_o = time_q;
  assign cmp_o  = cmp_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/csrt_lfsr.sv
module csrt_lfsr #(
  parameter int unsigned  W    = 32,
  parameter logic [W-1:0] TAPS = 32'h8020_0003,
  parameter logic [W-1:0] DEF  = 32'h1D87_2B41
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] seed,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;
  logic [W-1:0] tap_bits;
  logic         fb;
  logic [W-1:0] seed_safe;

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_tap
      if (TAPS[g]) begin : g_on
        assign tap_bits[g] = q[g];
      end else begin : g_off
        assign tap_bits[g] = 1'b0;
      end
    end
  endgenerate

  assign fb        = ^tap_bits;
  assign seed_safe = (seed == '0) ? DEF : seed;

  always_ff @(posedge clk) begin
    if (rst)       q <= DEF;
    else if (load) q <= seed_safe;
    else           q <= {q[W-2:0], fb};
  end

  assign q_o = q;
endmodule

// File: rtl/csrt_rd_select.sv
module csrt_rd_select
  import csrt_pkg::*;
#(
  parameter int unsigned           AW     = 12,
  parameter int unsigned           DW     = 32,
  parameter logic [AW-1:0]         A_TIME = 12'h7C0,
  parameter logic [AW-1:0]         A_CMP  = 12'h7C1,
  parameter logic [AW-1:0]         A_RAND = 12'h7C2
) (
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] time_v,
  input  logic [DW-1:0] cmp_v,
  input  logic [DW-1:0] rand_v,
  output csrt_sel_e     sel,
  output logic [DW-1:0] data
);
  always_comb begin
    if (addr == A_TIME)      sel = SEL_TIME;
    else if (addr == A_CMP)  sel = SEL_CMP;
    else if (addr == A_RAND) sel = SEL_RAND;
    else                     sel = SEL_NONE;
  end

  always_comb begin
    case (sel)
      SEL_TIME: data = time_v;
      SEL_CMP:  data = cmp_v;
      SEL_RAND: data = rand_v;
      default:  data = '0;
    endcase
  end
endmodule

// File: rtl/csr_timer_rng.sv
module csr_timer_rng
  import csrt_pkg::*;
#(
  parameter int unsigned        AW     = CSRT_ADDR_W,
  parameter int unsigned        DW     = CSRT_DATA_W,
  parameter logic [AW-1:0]      A_TIME = CSRT_A_TIME,
  parameter logic [AW-1:0]      A_CMP  = CSRT_A_CMP,
  parameter logic [AW-1:0]      A_RAND = CSRT_A_RAND,
  parameter logic [DW-1:0]      TAPS   = CSRT_RAND_TAPS,
  parameter logic [DW-1:0]      SEED0  = CSRT_RAND_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          priv_machine,
  input  logic [AW-1:0] csr_addr,
  input  logic          csr_wr_en,
  input  logic [DW-1:0] csr_wr_data,
  output logic [DW-1:0] csr_rd_data,
  input  logic          seed_load,
  input  logic [DW-1:0] seed_value,
  output logic          timer_irq
);
  logic [DW-1:0] time_w;
  logic [DW-1:0] cmp_w;
  logic [DW-1:0] lfsr_w;
  logic [DW-1:0] rd_mux;
  csrt_sel_e     rd_sel;
  logic          cmp_we;
  logic [DW-1:0] rd_q;

  csrt_rd_select #(
    .AW(AW), .DW(DW), .A_TIME(A_TIME), .A_CMP(A_CMP), .A_RAND(A_RAND)
  ) u_sel (
    .addr(csr_addr), .time_v(time_w), .cmp_v(cmp_w), .rand_v(lfsr_w),
    .sel(rd_sel), .data(rd_mux)
  );

  // Only the compare register accepts software writes, and only in machine mode
  assign cmp_we = priv_machine && csr_wr_en && (rd_sel == SEL_CMP);

  csrt_down_timer #(.W(DW)) u_tmr (
    .clk(clk), .rst(rst), .cmp_we(cmp_we), .cmp_wdata(csr_wr_data),
    .time_o(time_w), .cmp_o(cmp_w), .irq_o(timer_irq)
  );

  csrt_lfsr #(.W(DW), .TAPS(TAPS), .DEF(SEED0)) u_rng (
    .clk(clk), .rst(rst), .load(seed_load), .seed(seed_value), .q_o(lfsr_w)
  );

  always_ff @(posedge clk) begin
    if (rst)               rd_q <= '0;
    else if (priv_machine) rd_q <= rd_mux;
    else                   rd_q <= '0;
  end

  assign csr_rd_data = rd_q;
endmodule

// File: rtl/csr_timer_rng_chk.sv
module csr_timer_rng_chk #(
  parameter int unsigned   AW    = 12,
  parameter int unsigned   DW    = 32,
  parameter logic [AW-1:0] A_CMP = 12'h7C1
) (
  input logic          clk,
  input logic          rst,
  input logic          priv_machine,
  input logic [AW-1:0] csr_addr,
  input logic          csr_wr_en,
  input logic [DW-1:0] csr_wr_data,
  input logic [DW-1:0] csr_rd_data,
  input logic          seed_load,
  input logic [DW-1:0] seed_value,
  input logic          timer_irq,
  input logic [DW-1:0] time_w,
  input logic [DW-1:0] cmp_w,
  input logic [DW-1:0] lfsr_w
);
  logic sw_cmp;
  assign sw_cmp = priv_machine && csr_wr_en && (csr_addr == A_CMP);

  assert_time_step_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> time_w == $past(time_w) - DW'(1));

  assert_cmp_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sw_cmp)) |-> $stable(cmp_w));

  assert_cmp_load_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sw_cmp)) |-> cmp_w == $past(csr_wr_data));

  assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(timer_irq) && !$past(sw_cmp)) |-> timer_irq);

  assert_irq_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sw_cmp)) |-> !timer_irq);

  assert_seed_take_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(seed_load) && $past(seed_value) != '0)
      |-> lfsr_w == $past(seed_value));

  assert_rng_nonzero_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> lfsr_w != '0);

  assert_user_read_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(priv_machine)) |-> csr_rd_data == '0);
endmodule

bind csr_timer_rng csr_timer_rng_chk #(.AW(AW), .DW(DW), .A_CMP(A_CMP)) u_chk (
  .clk(clk), .rst(rst), .priv_machine(priv_machine), .csr_addr(csr_addr),
  .csr_wr_en(csr_wr_en), .csr_wr_data(csr_wr_data), .csr_rd_data(csr_rd_data),
  .seed_load(seed_load), .seed_value(seed_value), .timer_irq(timer_irq),
  .time_w(time_w), .cmp_w(cmp_w), .lfsr_w(lfsr_w)
);

// File: tb/csr_timer_rng_test.sv
module csr_timer_rng_test;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [11:0] AT = 12'h7C0;
  localparam logic [11:0] AC = 12'h7C1;
  localparam logic [11:0] AR = 12'h7C2;
  localparam logic [31:0] DEF = 32'h1D87_2B41;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        priv_machine = 1'b1;
  logic [11:0] csr_addr = AT;
  logic        csr_wr_en = 1'b0;
  logic [31:0] csr_wr_data = '0;
  logic [31:0] csr_rd_data;
  logic        seed_load = 1'b0;
  logic [31:0] seed_value = '0;
  logic        timer_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csr_timer_rng uut (
    .clk(clk), .rst(rst), .priv_machine(priv_machine), .csr_addr(csr_addr),
    .csr_wr_en(csr_wr_en), .csr_wr_data(csr_wr_data), .csr_rd_data(csr_rd_data),
    .seed_load(seed_load), .seed_value(seed_value), .timer_irq(timer_irq)
  );

  function automatic logic [31:0] step(logic [31:0] x);
    return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    csr_addr = a; csr_wr_en = 1'b0;
    @(posedge clk); #1;
    v = csr_rd_data;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    csr_addr = a; csr_wr_en = 1'b1; csr_wr_data = d;
    @(posedge clk); #1;
    csr_wr_en = 1'b0;
  endtask

  task automatic load_seed(logic [31:0] s);
    @(negedge clk);
    seed_load = 1'b1; seed_value = s;
    @(posedge clk); #1;
    seed_load = 1'b0;
  endtask

  task automatic do_reset(logic [11:0] a, logic [31:0] exp_first);
    @(negedge clk);
    rst = 1'b1; csr_addr = a; csr_wr_en = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rd_data in reset", csr_rd_data, 32'h0);
    chk("R1 irq in reset", {31'b0, timer_irq}, 32'h0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 first read after reset", csr_rd_data, exp_first);
  endtask

  task automatic t_time_count();
    logic [31:0] a, b, c;
    rd(AT, a); rd(AT, b);
    chk("R2 back-to-back decrement", b, a - 1);
    rd(AR, c); rd(AT, c);
    chk("R2 decrement over gap", c, a - 3);
    rd(12'h7C5, c);
    chk("R3 unmapped reads zero", c, 32'h0);
  endtask

  task automatic t_time_write_ignored();
    logic [31:0] a, b;
    rd(AT, a);
    wr(AT, 32'h1234_5678);
    rd(AT, b);
    chk("R5 time write ignored", b, a - 2);
  endtask

  task automatic t_irq(output logic [31:0] cmp_set);
    logic [31:0] t, c;
    bit early = 1'b0;
    rd(AT, t);
    wr(AC, t - 30);
    for (int i = 2; i <= 29; i++) begin
      @(posedge clk); #1;
      if (timer_irq) early = 1'b1;
    end
    chk("R6 no early irq", {31'b0, early}, 32'h0);
    @(posedge clk); #1;
    chk("R6 irq rises on match", {31'b0, timer_irq}, 32'h1);
    repeat (10) @(posedge clk);
    #1;
    chk("R6 irq sticky", {31'b0, timer_irq}, 32'h1);
    cmp_set = t - 500;
    wr(AC, cmp_set);
    chk("R7 compare write clears irq", {31'b0, timer_irq}, 32'h0);
    rd(AC, c);
    chk("R4 compare readback", c, cmp_set);
    chk("R7 irq stays clear", {31'b0, timer_irq}, 32'h0);
  endtask

  task automatic t_priv(logic [31:0] cmp_set);
    logic [31:0] v;
    @(negedge clk); priv_machine = 1'b0;
    wr(AC, 32'hDEAD_BEEF);
    rd(AC, v);
    chk("R11 non-machine read is zero", v, 32'h0);
    @(negedge clk); priv_machine = 1'b1;
    rd(AC, v);
    chk("R11 non-machine write ignored", v, cmp_set);
  endtask

  task automatic t_lfsr_seq();
    logic [31:0] m, v;
    m = 32'h0BAD_F00D;
    load_seed(m);
    for (int k = 0; k < 6; k++) begin
      rd(AR, v);
      chk("R8 R9 lfsr sequence", v, m);
      m = step(m);
    end
  endtask

  task automatic t_lfsr_zero();
    logic [31:0] v;
    load_seed(32'h0);
    rd(AR, v);
    chk("R10 zero seed replaced", v, DEF);
    rd(AR, v);
    chk("R8 step after default", v, step(DEF));
  endtask

  task automatic t_lfsr_write_ignored();
    logic [31:0] v;
    load_seed(32'h8000_0001);
    wr(AR, 32'hFFFF_FFFF);
    rd(AR, v);
    chk("R5 random write ignored", v, step(32'h8000_0001));
  endtask

  initial begin
    logic [31:0] cs;
    do_reset(AT, 32'hFFFF_FFFF);
    t_time_count();
    t_time_write_ignored();
    t_irq(cs);
    t_priv(cs);
    t_lfsr_seq();
    t_lfsr_zero();
    t_lfsr_write_ignored();
    do_reset(AR, DEF);
    do_reset(AC, 32'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule